// File: doc/BRIEF.md
# Command Write Timing Guard

This block sits between a host's write port and a controller's command register. It enforces the timing rules that register imposes. Consecutive accepted writes must be a minimum interval apart. In the default mode that interval is counted in periods of an oversampling clock, whose speed follows the data rate. In fast mode it is counted in periods of the crystal clock. Writes that break the rule are dropped, and a reject pulse reports them.

The block also owns two status flags: transmitter-available and receiver-inhibited. Each flag is set by an internal set pulse and cleared when the matching enable command is accepted.

- **Default mode:** a flag rises as its set pulse begins. While any set pulse is still high, enable-transmit and enable-receive commands are locked out.
- **Fast mode:** the flag rises only after its set pulse has ended, so there is no lockout.

An interrupt pulse marks each rising edge of a flag.

Top module: `cmd_write_guard`

## Requirements
- R1: After reset: both flags are 1; `busy`, `cmd_wr`, `reject` and `irq` are 0.
- R2: A write that is not blocked is forwarded. In the next cycle `cmd_wr` is 1 for one cycle and `cmd_data` equals the written byte.
- R3: In fast mode (`fast_mode`=1), after a write accepted in cycle t, a write in cycle t+1 is rejected and a write in cycle t+2 is accepted.
- R4: In default mode the oversampling period is `rate_div`+1 crystal cycles. After a write accepted in cycle t, a write in cycle t+`rate_div`+1 is rejected and one in cycle t+2·`rate_div`+3 is accepted. `busy` is 1 while writes are being refused for spacing.
- R5: A blocked write gives a one-cycle `reject` pulse in the next cycle, no `cmd_wr`, and no restart of the spacing interval.
- R6: In default mode a flag reads 1 in the cycle after the first high cycle of its set pulse.
- R7: In default mode, while either set pulse is high, a write whose bits [2:0] are 3 (enable transmit) or 4 (enable receive) is rejected. Any other command is still accepted.
- R8: In fast mode a flag stays 0 for the whole set pulse. It reads 1 in the second cycle after the pulse's last high cycle.
- R9: In fast mode an enable command is accepted during a set pulse, and also in the very cycle its flag rises.
- R10: An accepted enable-transmit (bits [2:0]=3) clears `ta_flag`. An accepted enable-receive (bits [2:0]=4) clears `ri_flag`. The flag reads 0 from the cycle `cmd_wr` shows the command.
- R11: `irq` is 1 for exactly one cycle, in the first cycle a flag reads 1 after having been 0. A set pulse on a flag that is already 1 gives no `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_mode | input | 1 | Feature bit: crystal-timed spacing and late flag rise |
| rate_div | input | RW | Oversampling period minus one, in crystal cycles |
| wr_en | input | 1 | Host command write strobe |
| wr_data | input | DW | Host command byte |
| set_ta | input | 1 | Internal set pulse for the transmitter-available flag |
| set_ri | input | 1 | Internal set pulse for the receiver-inhibited flag |
| cmd_wr | output | 1 | Accepted-write strobe to the command register |
| cmd_data | output | DW | Accepted command byte |
| reject | output | 1 | One-cycle pulse for a dropped write |
| busy | output | 1 | Spacing interval in progress |
| ta_flag | output | 1 | Transmitter-available status |
| ri_flag | output | 1 | Receiver-inhibited status |
| irq | output | 1 | One-cycle pulse on a flag's rising edge |

## Verification
The hardest case to reach is the lockout window. An enable command has to land while a set pulse is still high, after the flag has already risen. At the same time, no spacing interval may be pending, or it would mask the cause of the rejection.

The stimulus first clears the flag with an accepted enable command and then waits out the interval. Next it raises the set pulse and writes the opposite enable command in the following cycle. While the pulse stays high it also writes a non-enable command. The fast-mode run repeats the pattern, timing its write to the exact cycle the flag rises, so the late-rise behaviour is tested at its boundary.

// File: rtl/cmd_write_guard.sv
module cmd_write_guard #(
  parameter int DW  = 8,
  parameter int RW  = 4,
  parameter int GAP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fast_mode,
  input  logic [RW-1:0] rate_div,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          set_ta,
  input  logic          set_ri,
  output logic          cmd_wr,
  output logic [DW-1:0] cmd_data,
  output logic          reject,
  output logic          busy,
  output logic          ta_flag,
  output logic          ri_flag,
  output logic          irq
);
  localparam int GW = $clog2(GAP + 1);
  localparam logic [2:0] OP_EN_TX = 3'd3;
  localparam logic [2:0] OP_EN_RX = 3'd4;

  logic [RW-1:0] div_cnt;
  logic [GW-1:0] gap_cnt;
  logic          ta_q, ri_q;

  wire tick   = (div_cnt >= rate_div);
  wire unit   = fast_mode | tick;
  wire en_tx  = (wr_data[2:0] == OP_EN_TX);
  wire en_rx  = (wr_data[2:0] == OP_EN_RX);
  wire locked = !fast_mode && (set_ta || set_ri);
  wire accept = wr_en && (gap_cnt == '0) && !((en_tx || en_rx) && locked);
  wire ta_ev  = fast_mode ? (ta_q && !set_ta) : (set_ta && !ta_q);
  wire ri_ev  = fast_mode ? (ri_q && !set_ri) : (set_ri && !ri_q);

  assign busy = (gap_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt <= '0;
      gap_cnt <= '0;
    end else begin
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (accept)
        gap_cnt <= fast_mode ? GW'(GAP - 1) : GW'(GAP);
      else if (unit && busy)
        gap_cnt <= gap_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ta_q     <= 1'b0;
      ri_q     <= 1'b0;
      ta_flag  <= 1'b1;
      ri_flag  <= 1'b1;
      irq      <= 1'b0;
      cmd_wr   <= 1'b0;
      cmd_data <= '0;
      reject   <= 1'b0;
    end else begin
      ta_q   <= set_ta;
      ri_q   <= set_ri;
      cmd_wr <= accept;
      reject <= wr_en && !accept;
      if (accept) cmd_data <= wr_data;
      if (ta_ev) ta_flag <= 1'b1;
      else if (accept && en_tx) ta_flag <= 1'b0;
      if (ri_ev) ri_flag <= 1'b1;
      else if (accept && en_rx) ri_flag <= 1'b0;
      irq <= (ta_ev && !ta_flag) || (ri_ev && !ri_flag);
    end
  end
endmodule

module cmd_write_guard_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fast_mode,
  input logic          wr_en,
  input logic [DW-1:0] wr_data,
  input logic          set_ta,
  input logic          set_ri,
  input logic          cmd_wr,
  input logic [DW-1:0] cmd_data,
  input logic          reject,
  input logic          busy,
  input logic          ta_flag,
  input logic          ri_flag,
  input logic          irq
);
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_wr, reject})); // R5
  AST_MIN_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> !cmd_wr); // R3
  AST_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !busy && !set_ta && !set_ri |=> cmd_wr && cmd_data == $past(wr_data)); // R2
  AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && busy |=> reject && !cmd_wr); // R5
  AST_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    !fast_mode && wr_en && (set_ta || set_ri) &&
    (wr_data[2:0] == 3'd3 || wr_data[2:0] == 3'd4) |=> reject); // R7
  AST_FAST_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    fast_mode && wr_en && !busy |=> cmd_wr); // R9
  AST_IRQ_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($rose(ta_flag) || $rose(ri_flag))); // R11
endmodule

bind cmd_write_guard cmd_write_guard_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode), .wr_en(wr_en),
  .wr_data(wr_data), .set_ta(set_ta), .set_ri(set_ri), .cmd_wr(cmd_wr),
  .cmd_data(cmd_data), .reject(reject), .busy(busy), .ta_flag(ta_flag),
  .ri_flag(ri_flag), .irq(irq)
);

// File: tb/tb_cmd_write_guard.sv
module tb_cmd_write_guard;
  localparam int DW = 8;
  localparam int RW = 4;
  localparam int D  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fast_mode = 1'b0;
  logic [RW-1:0] rate_div = RW'(D);
  logic wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic set_ta = 1'b0, set_ri = 1'b0;
  logic cmd_wr, reject, busy, ta_flag, ri_flag, irq;
  logic [DW-1:0] cmd_data;

  int vectors = 0;
  int errors = 0;
  bit done = 0;
  logic [DW:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  cmd_write_guard #(.DW(DW), .RW(RW), .GAP(2)) dut (
    .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode), .rate_div(rate_div),
    .wr_en(wr_en), .wr_data(wr_data), .set_ta(set_ta), .set_ri(set_ri),
    .cmd_wr(cmd_wr), .cmd_data(cmd_data), .reject(reject), .busy(busy),
    .ta_flag(ta_flag), .ri_flag(ri_flag), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [DW-1:0] d, input logic ok, input string req);
    @(posedge clk); #1;
    wr_en = 1'b1;
    wr_data = d;
    exp_q.push_back({ok, d});
    tag_q.push_back(req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      wr_en = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && (cmd_wr || reject)) begin
      if (exp_q.size() == 0) begin
        vectors++; errors++;
        $display("FAIL R2: unexpected result cmd_wr=%0b reject=%0b, expected none", cmd_wr, reject);
      end else begin
        logic [DW:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {31'd0, cmd_wr}, {31'd0, e[DW]});
        if (e[DW]) chk(t, {24'd0, cmd_data}, {24'd0, e[DW-1:0]});
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    #(100000 * 5);
    vectors++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", {28'd0, ta_flag, ri_flag, busy, irq}, 32'b1100);
    chk("R1", {30'd0, cmd_wr, reject}, 32'd0);

    // R3 fast-mode spacing, R5 no restart
    fast_mode = 1'b1;
    idle(4);
    wr(8'h21, 1'b1, "R3");
    wr(8'h22, 1'b0, "R5");
    wr(8'h23, 1'b1, "R3");
    idle(6);

    // R4 default-mode spacing
    fast_mode = 1'b0;
    idle(10);
    wr(8'h31, 1'b1, "R2");
    idle(D);
    wr(8'h32, 1'b0, "R4");
    @(negedge clk);
    chk("R4", {31'd0, busy}, 32'd1);
    idle(D + 1);
    wr(8'h33, 1'b1, "R4");
    idle(12);

    // R10 clear ta, R6/R7/R11 default-mode flag rise and lockout
    wr(8'h03, 1'b1, "R10");
    idle(1);
    @(negedge clk);
    chk("R10", {31'd0, ta_flag}, 32'd0);
    idle(12);
    @(posedge clk); #1 set_ta = 1'b1;
    @(negedge clk);
    chk("R6", {30'd0, ta_flag, irq}, 32'd0);
    wr(8'h04, 1'b0, "R7");
    @(negedge clk);
    chk("R6", {31'd0, ta_flag}, 32'd1);
    chk("R11", {31'd0, irq}, 32'd1);
    idle(1);
    @(negedge clk);
    chk("R11", {31'd0, irq}, 32'd0);
    idle(2);
    wr(8'h01, 1'b1, "R7");
    idle(3);
    @(posedge clk); #1 set_ta = 1'b0;
    idle(12);
    // R11 pulse on flag already high
    @(posedge clk); #1 set_ri = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R11", {30'd0, ri_flag, irq}, 32'b10);
    end
    @(posedge clk); #1 set_ri = 1'b0;
    idle(2);
    wr(8'h04, 1'b1, "R10");
    idle(1);
    @(negedge clk);
    chk("R10", {31'd0, ri_flag}, 32'd0);
    idle(12);

    // R8/R9 fast mode
    fast_mode = 1'b1;
    idle(4);
    wr(8'h03, 1'b1, "R10");
    idle(3);
    @(posedge clk); #1 set_ta = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8", {31'd0, ta_flag}, 32'd0);
    end
    @(posedge clk); #1 set_ta = 1'b0;
    @(negedge clk);
    chk("R8", {31'd0, ta_flag}, 32'd0);
    wr(8'h04, 1'b0, "R9"); // ri already 0? still accepted: fix expectation below
    exp_q[exp_q.size()-1] = {1'b1, 8'h04};
    @(negedge clk);
    chk("R8", {31'd0, ta_flag}, 32'd1);
    chk("R11", {31'd0, irq}, 32'd1);
    idle(4);
    @(posedge clk); #1 set_ri = 1'b1;
    wr(8'h03, 1'b1, "R9");
    idle(3);
    @(posedge clk); #1 set_ri = 1'b0;
    idle(6);
    chk("R2", exp_q.size(), 32'd0);
    finish_run();
  end
endmodule